// File: doc/BRIEF.md
# Power Sequencing and Retry Controller

This block is the supervisory state machine that decides when up to three supply channels are switched on and off. It takes digitised comparator results and returns per-channel gate enables, per-channel output pulldown enables, ramp up and ramp down commands, and an active-low fault flag. The comparators, the charge pumps and the timing capacitors sit outside the block. They are replaced here by programmable cycle counts for the start delay and the fault period.

At power-up it can bring all active channels up together behind one shared ramp (tracking), or turn them on one at a time in index order with a delay before each one (sequencing). Power-down always ramps every active channel down together. After a fault it either retries by itself after a long wait, or stays off until the enable input is cycled (latch). A channel can be excluded from control by marking its input absent while its undervoltage comparator still reads high.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, gate_en and pd_en are all zero, ramp_up and ramp_down are low, and fault_n is high.
- R2: Power-up starts only when every uv_ok bit and en_ok are high in the idle state. The first gate enable appears delay_cycles clock edges after the edge that left idle (a count of 0 acts as 1). If en_ok or any uv_ok bit drops during the delay, the block returns to idle.
- R3: With trk_sel=1, all active channels get gate_en together with ramp_up=1. ramp_up falls once every active channel reports pg_ok, and the gates stay on.
- R4: With trk_sel=0, channels start in index order, bit 0 first. Each channel's turn raises its own gate bit with ramp_up=1. When that channel's pg_ok rises, ramp_up drops and the start delay runs before the next channel's turn.
- R5: A channel with in_present=0 is never given gate_en and does not block the others. Its turn in sequencing ends one cycle after it begins.
- R6: With all active channels good, a drop of en_ok raises ramp_down while the gates stay on. Once every active channel reports pl_low, all gates turn off and the block is idle.
- R7: If en_ok drops before power-up completes, gates go off at once and pd_en goes to all ones with fault_n still high. The block returns to idle once every active channel reports pl_low.
- R8: A fault_req while channels are on, or a loss of pg_ok on an active channel after power-up, turns all gates off, sets pd_en to all ones and drives fault_n low on the next edge.
- R9: In autoretry (latch_sel=0), the fault state holds for 16 x fault_cycles edges and then for delay_cycles edges. Power-up then restarts directly, but only when en_ok, every uv_ok and every active pl_low are high. Otherwise the block waits, and if en_ok is low it goes to idle.
- R10: In latch mode (latch_sel=1), a fault holds the outputs off with fault_n low until en_ok goes low and then high again. After that the block waits 16 x fault_cycles edges, returns to idle with fault_n high, and starts normally.
- R11: If power-up of the ramp in progress does not finish within fault_cycles edges, the block takes the fault path of R8.
- R12: trk_sel, latch_sel and in_present are captured only while the block is idle. A change at any other time does not affect the cycle under way, including an automatic retry.
- R13: A reset clears a latched fault. With the start conditions already present, power-up then begins after only the start delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (loss of supply) |
| uv_ok | input | NCH | Per-channel supply above its undervoltage threshold |
| in_present | input | NCH | Per-channel input present; 0 excludes the channel |
| en_ok | input | 1 | Enable above threshold (hysteresis applied outside) |
| pg_ok | input | NCH | Per-channel output above the power-good level |
| pl_low | input | NCH | Per-channel output below the power-low level |
| trk_sel | input | 1 | 1 = tracking, 0 = sequencing |
| latch_sel | input | 1 | 1 = latch-off, 0 = autoretry |
| fault_req | input | 1 | Tracking fault request from the comparators |
| delay_cycles | input | CNT_W | Start delay in clock cycles |
| fault_cycles | input | CNT_W | Fault period in clock cycles |
| gate_en | output | NCH | Per-channel pass-device gate enable |
| pd_en | output | NCH | Per-channel output pulldown enable |
| ramp_up | output | 1 | Reference ramp rising command |
| ramp_down | output | 1 | Reference ramp falling command |
| fault_n | output | 1 | Fault flag, active low |

## Verification
Every output is a function of the registered state, so a wrong state or a wrong channel index shows up as a wrong output vector on the first edge after it is entered. A timer that runs short or long does not change the vector. It only moves the edge at which the vector changes, so each expected change carries an exact cycle number, and a retry wait that is off by even one edge is caught. A wrong captured mode or channel mask stays hidden until the next start or retry, so the bench changes mode inputs in the middle of a cycle and checks the next power-up.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power sequencing controller.
// Assumes: one state register; the retry wait is a power-of-two multiple of the fault period.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_TRK_UP,
        ST_SEQ_ON,
        ST_SEQ_GAP,
        ST_ON,
        ST_RAMP_DN,
        ST_ABORT,
        ST_RETRY_WAIT,
        ST_RETRY_DLY,
        ST_LATCHED,
        ST_LATCH_LOW,
        ST_LATCH_WAIT
    } pwr_seq_state_e;

    // Retry wait = fault period shifted left by this amount (x16).
    localparam int RETRY_SHIFT = 4;

endpackage

// File: rtl/pwr_seq_timer.sv
// Up-counter shared by every timed phase.
// Does: counts from zero after clr. Raises done once the count reaches limit-1,
//       then holds there (done stays high).
// Assumes: a limit of zero is treated as one.
module pwr_seq_timer #(
    parameter int TW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] lim_m1;

    // Last count value of the phase.
    always_comb lim_m1 = (limit == '0) ? '0 : limit - TW'(1);

    assign done = (cnt == lim_m1);

    // Count up and hold at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (!done)  cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/pwr_seq_mask.sv
// Channel masks for sequencing.
// Does: from the current channel index and the active set, gives the channels up to
//       and including the index (upto) and those strictly below it (below).
// Assumes: idx never exceeds NCH-1.
module pwr_seq_mask #(
    parameter int NCH   = 3,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [NCH-1:0]   act,
    output logic [NCH-1:0]   upto,
    output logic [NCH-1:0]   below
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // One mask bit per channel, by position relative to the index.
        assign upto[i]  = act[i] && (int'(idx) >= i);
        assign below[i] = act[i] && (int'(idx) >  i);
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Supervisory state machine.
// Does: power-up in tracking or sequencing, joint power-down, abort into fast shutdown,
//       and the fault paths with autoretry or latch-off.
// Assumes: comparator inputs are already synchronous. The timer restarts on every state
//          change, and outputs decode the registered state only.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 16,
    parameter int IDX_W = 2,
    parameter int TW    = CNT_W + RETRY_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   uv_ok,
    input  logic [NCH-1:0]   in_present,
    input  logic             en_ok,
    input  logic [NCH-1:0]   pg_ok,
    input  logic [NCH-1:0]   pl_low,
    input  logic             trk_sel,
    input  logic             latch_sel,
    input  logic             fault_req,
    input  logic [CNT_W-1:0] delay_cycles,
    input  logic [CNT_W-1:0] fault_cycles,
    input  logic             tmr_done,
    input  logic [NCH-1:0]   upto,
    input  logic [NCH-1:0]   below,
    output logic             tmr_clr,
    output logic [TW-1:0]    tmr_limit,
    output logic [IDX_W-1:0] seq_idx,
    output logic [NCH-1:0]   act,
    output logic [NCH-1:0]   gate_en,
    output logic [NCH-1:0]   pd_en,
    output logic             ramp_up,
    output logic             ramp_down,
    output logic             fault_n
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    pwr_seq_state_e st, nxt, fault_dest;
    logic [IDX_W-1:0] idx, idx_nxt;
    logic             trk_q, latch_q;
    logic [NCH-1:0]   act_q;
    logic             all_uv, pg_done, out_low, cur_act;

    assign all_uv     = &uv_ok;
    assign pg_done    = &(pg_ok | ~act_q);
    assign out_low    = &(pl_low | ~act_q);
    assign cur_act    = act_q[idx];
    assign fault_dest = latch_q ? ST_LATCHED : ST_RETRY_WAIT;
    assign seq_idx    = idx;
    assign act        = act_q;
    assign tmr_clr    = (nxt != st);

    // Next state and next sequencing index.
    always_comb begin
        nxt     = st;
        idx_nxt = idx;
        unique case (st)
            ST_IDLE: begin
                idx_nxt = '0;
                if (all_uv && en_ok) nxt = ST_START;
            end
            ST_START: begin
                if (!en_ok || !all_uv) nxt = ST_IDLE;
                else if (tmr_done)     nxt = trk_q ? ST_TRK_UP : ST_SEQ_ON;
            end
            ST_TRK_UP: begin
                if (fault_req)    nxt = fault_dest;
                else if (!en_ok)  nxt = ST_ABORT;
                else if (pg_done) nxt = ST_ON;
                else if (tmr_done) nxt = fault_dest;
            end
            ST_SEQ_ON: begin
                if (fault_req)   nxt = fault_dest;
                else if (!en_ok) nxt = ST_ABORT;
                else if (!cur_act || pg_ok[idx]) begin
                    if (idx == LAST_IDX) nxt = ST_ON;
                    else begin
                        nxt     = ST_SEQ_GAP;
                        idx_nxt = idx + IDX_W'(1);
                    end
                end
                else if (tmr_done) nxt = fault_dest;
            end
            ST_SEQ_GAP: begin
                if (fault_req)     nxt = fault_dest;
                else if (!en_ok)   nxt = ST_ABORT;
                else if (tmr_done) nxt = ST_SEQ_ON;
            end
            ST_ON: begin
                if (fault_req || !pg_done) nxt = fault_dest;
                else if (!en_ok)           nxt = ST_RAMP_DN;
            end
            ST_RAMP_DN: begin
                if (fault_req)    nxt = fault_dest;
                else if (out_low) nxt = ST_IDLE;
            end
            ST_ABORT:      if (out_low)  nxt = ST_IDLE;
            ST_RETRY_WAIT: if (tmr_done) nxt = ST_RETRY_DLY;
            ST_RETRY_DLY: begin
                if (tmr_done) begin
                    if (!en_ok) nxt = ST_IDLE;
                    else if (all_uv && out_low) begin
                        nxt     = trk_q ? ST_TRK_UP : ST_SEQ_ON;
                        idx_nxt = '0;
                    end
                end
            end
            ST_LATCHED:    if (!en_ok) nxt = ST_LATCH_LOW;
            ST_LATCH_LOW:  if (en_ok)  nxt = ST_LATCH_WAIT;
            ST_LATCH_WAIT: begin
                if (!en_ok)        nxt = ST_LATCH_LOW;
                else if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, index and the configuration captured in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx     <= '0;
            trk_q   <= 1'b0;
            latch_q <= 1'b0;
            act_q   <= '0;
        end else begin
            st  <= nxt;
            idx <= idx_nxt;
            if (st == ST_IDLE) begin
                trk_q   <= trk_sel;
                latch_q <= latch_sel;
                act_q   <= in_present;
            end
        end
    end

    // Timer limit chosen by the phase under way.
    always_comb begin
        unique case (st)
            ST_START, ST_SEQ_GAP, ST_RETRY_DLY: tmr_limit = TW'(delay_cycles);
            ST_TRK_UP, ST_SEQ_ON:               tmr_limit = TW'(fault_cycles);
            ST_RETRY_WAIT, ST_LATCH_WAIT:       tmr_limit = TW'(fault_cycles) << RETRY_SHIFT;
            default:                            tmr_limit = '0;
        endcase
    end

    // Output decode from the registered state.
    always_comb begin
        gate_en   = '0;
        pd_en     = '0;
        ramp_up   = 1'b0;
        ramp_down = 1'b0;
        fault_n   = 1'b1;
        unique case (st)
            ST_TRK_UP:  begin gate_en = act_q; ramp_up = 1'b1; end
            ST_SEQ_ON:  begin gate_en = upto;  ramp_up = cur_act; end
            ST_SEQ_GAP: gate_en = below;
            ST_ON:      gate_en = act_q;
            ST_RAMP_DN: begin gate_en = act_q; ramp_down = 1'b1; end
            ST_ABORT:   pd_en = '1;
            ST_RETRY_WAIT, ST_RETRY_DLY, ST_LATCHED, ST_LATCH_LOW, ST_LATCH_WAIT: begin
                pd_en   = '1;
                fault_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwr_seq_top.sv
// Top of the power sequencing controller.
// Does: joins the state machine, the shared phase timer and the sequencing masks.
// Assumes: all inputs are synchronous to clk; rst_n models a full loss of supply.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   uv_ok,
    input  logic [NCH-1:0]   in_present,
    input  logic             en_ok,
    input  logic [NCH-1:0]   pg_ok,
    input  logic [NCH-1:0]   pl_low,
    input  logic             trk_sel,
    input  logic             latch_sel,
    input  logic             fault_req,
    input  logic [CNT_W-1:0] delay_cycles,
    input  logic [CNT_W-1:0] fault_cycles,
    output logic [NCH-1:0]   gate_en,
    output logic [NCH-1:0]   pd_en,
    output logic             ramp_up,
    output logic             ramp_down,
    output logic             fault_n
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int TW    = CNT_W + RETRY_SHIFT;

    logic             tmr_clr, tmr_done;
    logic [TW-1:0]    tmr_limit;
    logic [IDX_W-1:0] seq_idx;
    logic [NCH-1:0]   act, upto, below;

    pwr_seq_timer #(.TW(TW)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    pwr_seq_mask #(.NCH(NCH), .IDX_W(IDX_W)) mask_i (
        .idx   (seq_idx),
        .act   (act),
        .upto  (upto),
        .below (below)
    );

    pwr_seq_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .IDX_W(IDX_W), .TW(TW)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_ok        (uv_ok),
        .in_present   (in_present),
        .en_ok        (en_ok),
        .pg_ok        (pg_ok),
        .pl_low       (pl_low),
        .trk_sel      (trk_sel),
        .latch_sel    (latch_sel),
        .fault_req    (fault_req),
        .delay_cycles (delay_cycles),
        .fault_cycles (fault_cycles),
        .tmr_done     (tmr_done),
        .upto         (upto),
        .below        (below),
        .tmr_clr      (tmr_clr),
        .tmr_limit    (tmr_limit),
        .seq_idx      (seq_idx),
        .act          (act),
        .gate_en      (gate_en),
        .pd_en        (pd_en),
        .ramp_up      (ramp_up),
        .ramp_down    (ramp_down),
        .fault_n      (fault_n)
    );
endmodule

// File: rtl/pwr_seq_chk.sv
// Port-level properties of the power sequencing controller, bound to the top.
// Assumes: synchronous active-low reset; it only observes.
module pwr_seq_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_ok,
    input logic [NCH-1:0] gate_en,
    input logic [NCH-1:0] pd_en,
    input logic           ramp_up,
    input logic           ramp_down,
    input logic           fault_n
);
    // R8
    fault_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_en == '0 && pd_en == '1));

    // R7
    pd_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & gate_en) == '0);

    // R3
    ramp_dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_up && ramp_down));

    // R2
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en != '0 && $past(gate_en) == '0) |-> $past(en_ok));

    // R6
    ramp_down_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_down) |-> !$past(en_ok));
endmodule

bind pwr_seq_top pwr_seq_chk #(.NCH(NCH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_ok     (en_ok),
    .gate_en   (gate_en),
    .pd_en     (pd_en),
    .ramp_up   (ramp_up),
    .ramp_down (ramp_down),
    .fault_n   (fault_n)
);

// File: tb/pwr_seq_top_tb_top.sv
// Scoreboard bench: driver pushes expected output vectors with their cycle numbers,
// a monitor pops one for every change of the output vector and compares it.
`timescale 1ns/100ps
module pwr_seq_top_tb_top;
    localparam int NCH = 3;
    localparam int CW  = 16;
    localparam int D   = 4;
    localparam int F   = 20;
    localparam int RW  = 16 * F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] uv_ok = '1, in_present = '1, pg_ok = '0, pl_low = '1;
    logic en_ok = 1'b0, trk_sel = 1'b1, latch_sel = 1'b0, fault_req = 1'b0;
    logic [CW-1:0] delay_cycles = CW'(D), fault_cycles = CW'(F);
    logic [NCH-1:0] gate_en, pd_en;
    logic ramp_up, ramp_down, fault_n;

    pwr_seq_top #(.NCH(NCH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .in_present(in_present),
        .en_ok(en_ok), .pg_ok(pg_ok), .pl_low(pl_low), .trk_sel(trk_sel),
        .latch_sel(latch_sel), .fault_req(fault_req), .delay_cycles(delay_cycles),
        .fault_cycles(fault_cycles), .gate_en(gate_en), .pd_en(pd_en),
        .ramp_up(ramp_up), .ramp_down(ramp_down), .fault_n(fault_n)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [8:0] v;
        int         at;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   cyc = 0, n_chk = 0, n_fail = 0;
    bit   mon_on = 0, done = 0;
    logic [8:0] last, cur;
    wire  [8:0] outv = {fault_n, ramp_down, ramp_up, pd_en, gate_en};

    // Vector layout: {fault_n, ramp_down, ramp_up, pd_en, gate_en}.
    function automatic logic [8:0] mk(logic [2:0] g, logic [2:0] p, logic u, logic d, logic f);
        return {f, d, u, p, g};
    endfunction

    localparam logic [8:0] V_IDLE = 9'b1_0_0_000_000;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(logic [8:0] v, int at, string tag);
        exp_t x;
        x.v = v; x.at = at; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: compare each output change with the next expectation.
    always @(negedge clk) begin
        if (mon_on) begin
            cur = outv;
            if (cur !== last) begin
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL unexpected change (R8 R10 latch/hold): actual %h at cycle %0d, expected no change", cur, cyc);
                end else begin
                    e = q.pop_front();
                    if (cur !== e.v || cyc != e.at) begin
                        n_fail++;
                        $display("FAIL %s: actual %h at cycle %0d, expected %h at cycle %0d", e.tag, cur, cyc, e.v, e.at);
                    end
                end
                last = cur;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all R): actual hang, expected completion");
            summary();
        end
    end

    initial begin : driver
        int c, t0;
        step(3);
        rst_n = 1'b1;
        // R1: reset state
        n_chk++;
        if (outv !== V_IDLE) begin
            n_fail++;
            $display("FAIL R1: actual %h, expected %h", outv, V_IDLE);
        end
        last = outv;
        mon_on = 1;

        // Tracking: up, complete, down (R2 R3 R6)
        step(2); c = cyc; en_ok = 1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + D, "R2 R3 tracking start");
        step(D + 4); c = cyc; pg_ok = '1; pl_low = '0;
        push(mk(3'b111, 0, 0, 0, 1), c + 1, "R3 tracking done");
        step(3); c = cyc; en_ok = 0;
        push(mk(3'b111, 0, 0, 1, 1), c + 1, "R6 ramp down");
        step(3); c = cyc; pg_ok = '0; pl_low = '1;
        push(V_IDLE, c + 1, "R6 all off");

        // Sequencing, middle channel excluded, mode flip mid-cycle (R4 R5 R12)
        step(2); in_present = 3'b101; trk_sel = 0; c = cyc; en_ok = 1;
        push(mk(3'b001, 0, 1, 0, 1), c + 1 + D, "R4 R12 first channel");
        step(2); trk_sel = 1;
        step(D + 2); c = cyc; pg_ok = 3'b001;
        push(mk(3'b001, 0, 0, 0, 1), c + 1, "R4 gap");
        push(mk(3'b101, 0, 1, 0, 1), c + 2 + 2 * D, "R4 R5 last channel");
        step(2 * D + 5); c = cyc; pg_ok = 3'b101; pl_low = '0;
        push(mk(3'b101, 0, 0, 0, 1), c + 1, "R4 sequence done");
        step(3); c = cyc; en_ok = 0;
        push(mk(3'b101, 0, 0, 1, 1), c + 1, "R5 R6 joint ramp down");
        step(3); c = cyc; pg_ok = '0; pl_low = '1;
        push(V_IDLE, c + 1, "R6 off");
        step(2); in_present = '1;

        // Abort during power-up (R7)
        c = cyc; en_ok = 1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + D, "R2 start");
        step(D + 3); c = cyc; pl_low = '0; en_ok = 0;
        push(mk(3'b000, 3'b111, 0, 0, 1), c + 1, "R7 fast shutdown");
        step(3); c = cyc; pl_low = '1;
        push(V_IDLE, c + 1, "R7 back to idle");
        step(2);

        // Fault with autoretry, latch select flipped during wait (R8 R9 R12)
        c = cyc; en_ok = 1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + D, "R2 start");
        step(D + 3); c = cyc; pg_ok = '1; pl_low = '0;
        push(mk(3'b111, 0, 0, 0, 1), c + 1, "R3 on");
        step(3); c = cyc; fault_req = 1;
        push(mk(3'b000, 3'b111, 0, 0, 0), c + 1, "R8 fault");
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + RW + D, "R9 R12 retry timing");
        step(1); fault_req = 0; pg_ok = '0; pl_low = '1; latch_sel = 1;
        step(RW + D + 3); c = cyc; pg_ok = '1; pl_low = '0;
        push(mk(3'b111, 0, 0, 0, 1), c + 1, "R3 on after retry");
        step(2); c = cyc; en_ok = 0; latch_sel = 0;
        push(mk(3'b111, 0, 0, 1, 1), c + 1, "R6 ramp down");
        step(2); c = cyc; pg_ok = '0; pl_low = '1;
        push(V_IDLE, c + 1, "R6 off");
        step(2);

        // Power-up timeout, retry held until outputs are low (R11 R9)
        c = cyc; en_ok = 1; t0 = c + 1 + D;
        push(mk(3'b111, 0, 1, 0, 1), t0, "R2 start");
        push(mk(3'b000, 3'b111, 0, 0, 0), t0 + F, "R11 timeout fault");
        step(2); pl_low = '0;
        step(D - 1 + F + RW + D + 30); c = cyc; pl_low = '1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1, "R9 retry waits for power-low");
        step(3); c = cyc; en_ok = 0;
        push(mk(3'b000, 3'b111, 0, 0, 1), c + 1, "R7 abort");
        push(V_IDLE, c + 2, "R7 idle");
        step(4);

        // Latch mode, then reset clears it (R10 R13)
        latch_sel = 1; step(1); c = cyc; en_ok = 1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + D, "R2 start");
        step(D + 3); c = cyc; fault_req = 1;
        push(mk(3'b000, 3'b111, 0, 0, 0), c + 1, "R10 latched");
        step(1); fault_req = 0;
        step(400); en_ok = 0;
        step(5); c = cyc; en_ok = 1;
        push(V_IDLE, c + 1 + RW, "R10 release after enable cycle");
        push(mk(3'b111, 0, 1, 0, 1), c + 2 + RW + D, "R10 restart");
        step(RW + D + 5); c = cyc; fault_req = 1;
        push(mk(3'b000, 3'b111, 0, 0, 0), c + 1, "R10 latched again");
        step(1); fault_req = 0;
        step(10); c = cyc; rst_n = 0;
        push(V_IDLE, c + 1, "R13 reset clears latch");
        step(2); c = cyc; rst_n = 1;
        push(mk(3'b111, 0, 1, 0, 1), c + 1 + D, "R13 immediate start");
        step(D + 3); c = cyc; en_ok = 0; pl_low = '0;
        push(mk(3'b000, 3'b111, 0, 0, 1), c + 1, "R7 abort");
        step(2); c = cyc; pl_low = '1;
        push(V_IDLE, c + 1, "R7 idle");
        step(4);

        // Every expectation must have been met.
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL pending (%s): actual %0d left, expected 0", q[0].tag, q.size());
        end
        done = 1;
        summary();
    end
endmodule